// File: doc/BRIEF.md
# Prefetching Line Read Buffer Controller

This block sits between a system bus read port and a slow memory array that delivers one whole line per access. It keeps a small set of line buffers. Each buffer holds a line, a line tag and a valid flag. A read that finds its line in a buffer is answered in the cycle it is presented. A read that misses starts an array access. When the array returns the line, the requested word goes to the bus and the line is written into a buffer, both in the same cycle.

After a demand fill the controller can fetch the next sequential line on its own. This speculative fetch is filtered by access type and by bus master. Demand fills take the most-recently-used position at once. A speculative line goes into the least-recently-used eligible slot and keeps that position until a later hit promotes it. Software masks decide which buffers instruction fetches may allocate and which buffers data fetches may allocate.

The bus holds `req_valid`, `req_addr`, `req_instr` and `req_master` steady until it sees `resp_valid`, and changes or drops them after that cycle. The controller is a three-state machine:
- `ST_IDLE`: lookups are served here.
- `ST_FETCH`: a demand line is outstanding.
- `ST_PREFETCH`: a speculative line is outstanding.

Its transitions are:
- `T_MISS`: `ST_IDLE` to `ST_FETCH`, taken on a lookup miss.
- `T_FILL`: `ST_FETCH` to `ST_IDLE`, taken on a demand ack when no prefetch is due.
- `T_FILL_PF`: `ST_FETCH` to `ST_PREFETCH`, taken on a demand ack when a prefetch is due.
- `T_PF_DONE`: `ST_PREFETCH` to `ST_IDLE`, taken on a prefetch ack.
- A hit keeps the machine in `ST_IDLE`.

Top module: `lrb_prefetch_ctrl`

## Requirements
- R1: In `ST_IDLE`, a valid request whose line tag matches a valid buffer gets `resp_valid` and the addressed word in the same cycle, and that buffer becomes most recently used.
- R2: A lookup miss raises `arr_req` on the next cycle with `arr_line_addr` = `req_addr[ADDR_W-1:OFF_W]`. `arr_req` and `arr_line_addr` hold until `arr_ack`. In the ack cycle, `resp_valid` is high and `resp_data` is word `req_addr[OFF_W-1:0]` of `arr_line`, where word w sits in bits `[w*DATA_W +: DATA_W]`.
- R3: A demand line is stored in the eligible buffer that has the oldest rank, and that buffer becomes most recently used. The buffers that were more recent than it each age by one place, so the least recently used eligible buffer is the one evicted.
- R4: `pf_mode` selects the access types that trigger a prefetch: 2'b00 none, 2'b01 instruction only (`req_instr`=1), 2'b10 data only, 2'b11 any.
- R5: A prefetch is triggered only if `pf_master_en[req_master]` is 1.
- R6: When a triggered demand fill is acked, the cycle after it raises `arr_req` for line address + 1. This happens only if that line is not already buffered and some buffer is eligible.
- R7: A prefetched line goes into the oldest eligible buffer and leaves every rank unchanged, so it is the next victim unless a hit promotes it first.
- R8: While a prefetch is outstanding, no request is answered. A request for the prefetched line is answered as a hit, from the buffer, once the prefetch completes, with no further array access.
- R9: `alloc_instr_en[i]` and `alloc_data_en[i]` allow instruction and data fills respectively to use buffer i. With no eligible buffer the word is still returned but the line is not kept. Lookups ignore access type.
- R10: After reset all buffers are invalid, the state is `ST_IDLE`, `resp_valid` and `arr_req` are 0, and buffer i holds rank i.
- R11: The buffer ranks always form a permutation of 0 to NBUF-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus read request present |
| req_addr | input | ADDR_W | Word address of the read |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| req_master | input | MST_W | Requesting bus master |
| resp_valid | output | 1 | Read data valid this cycle |
| resp_data | output | DATA_W | Read data |
| pf_mode | input | 2 | Prefetch trigger type select |
| pf_master_en | input | NMST | Per-master prefetch enable |
| alloc_instr_en | input | NBUF | Buffers usable by instruction fills |
| alloc_data_en | input | NBUF | Buffers usable by data fills |
| arr_req | output | 1 | Array access outstanding |
| arr_line_addr | output | LINE_W | Line address for the array |
| arr_ack | input | 1 | Array line returned this cycle |
| arr_line | input | WORDS*DATA_W | Returned line |

## Verification
Timing of the results:
- A hit is due in the same cycle as the request, so the bench applies the request and samples `resp_valid` a short delay later in that cycle. A response in that first sample is what counts as a hit.
- A miss response is due in the cycle `arr_ack` is high. The bench model raises `arr_ack` a fixed number of cycles after `arr_req` and polls once per cycle until the response appears.
- A prefetch, when due, starts the cycle after the demand ack and completes a few cycles later. The bench therefore idles for several cycles before counting array accesses and reading the last line address.

Replacement order is never read directly. It is inferred from which earlier lines still hit and which now miss.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH    = 2'd1,
        ST_PREFETCH = 2'd2
    } lrb_state_e;

    // Trigger select: bit 0 admits instruction fetches, bit 1 admits data reads
    function automatic logic pf_type_ok(input logic [1:0] mode, input logic is_instr);
        return is_instr ? mode[0] : mode[1];
    endfunction

endpackage

// File: rtl/lrb_lru_rank.sv
module lrb_lru_rank #(
    parameter int NBUF = 4,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       promote,
    input  logic [IDX_W-1:0]           promote_idx,
    output logic [NBUF-1:0][IDX_W-1:0] rank
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBUF; i++) rank[i] <= IDX_W'(i);
        end else if (promote) begin
            for (int i = 0; i < NBUF; i++) begin
                if (IDX_W'(i) == promote_idx)
                    rank[i] <= '0;
                else if (rank[i] < rank[promote_idx])
                    rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    // R11: every rank value is held by exactly one buffer
    for (genvar v = 0; v < NBUF; v++) begin : g_perm
        logic [NBUF-1:0] owner;
        always_comb begin
            for (int i = 0; i < NBUF; i++) owner[i] = (rank[i] == IDX_W'(v));
        end
        a_r11_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(owner) == 1);
    end

endmodule

// File: rtl/lrb_victim_sel.sv
module lrb_victim_sel #(
    parameter int NBUF = 4,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [NBUF-1:0][IDX_W-1:0] rank,
    input  logic [NBUF-1:0]            elig,
    output logic [IDX_W-1:0]           victim,
    output logic                       any_elig
);

    logic [IDX_W-1:0] oldest;

    always_comb begin
        any_elig = 1'b0;
        victim   = '0;
        oldest   = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (elig[i] && (!any_elig || rank[i] > oldest)) begin
                any_elig = 1'b1;
                oldest   = rank[i];
                victim   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lrb_prefetch_ctrl.sv
module lrb_prefetch_ctrl
    import lrb_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int NMST   = 4,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int LBITS  = WORDS * DATA_W,
    localparam int MST_W  = (NMST > 1) ? $clog2(NMST) : 1,
    localparam int IDX_W  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_instr,
    input  logic [MST_W-1:0]  req_master,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    input  logic [1:0]        pf_mode,
    input  logic [NMST-1:0]   pf_master_en,
    input  logic [NBUF-1:0]   alloc_instr_en,
    input  logic [NBUF-1:0]   alloc_data_en,
    output logic              arr_req,
    output logic [LINE_W-1:0] arr_line_addr,
    input  logic              arr_ack,
    input  logic [LBITS-1:0]  arr_line
);

    lrb_state_e state_q, state_d;

    logic [NBUF-1:0]              vld_q;
    logic [LINE_W-1:0]            tag_q  [NBUF];
    logic [LBITS-1:0]             line_q [NBUF];
    logic [OFF_W-1:0]             cur_word_q;
    logic                         cur_instr_q;
    logic [MST_W-1:0]             cur_master_q;
    logic [LINE_W-1:0]            arr_addr_q;

    logic [LINE_W-1:0]            req_line, next_line;
    logic [OFF_W-1:0]             req_word;
    logic                         hit, next_hit;
    logic [IDX_W-1:0]             hit_idx;
    logic [NBUF-1:0]              elig;
    logic [IDX_W-1:0]             victim;
    logic                         any_elig;
    logic [NBUF-1:0][IDX_W-1:0]   rank;
    logic                         promote;
    logic [IDX_W-1:0]             promote_idx;
    logic                         take_hit, take_miss, fill_ack, pf_ack, pf_go;

    assign req_line  = req_addr[ADDR_W-1:OFF_W];
    assign req_word  = req_addr[OFF_W-1:0];
    assign next_line = arr_addr_q + {{(LINE_W-1){1'b0}}, 1'b1};

    // Tag lookup for the bus request and for the candidate next line
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        next_hit = 1'b0;
        for (int i = 0; i < NBUF; i++) begin
            if (vld_q[i] && tag_q[i] == req_line) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (vld_q[i] && tag_q[i] == next_line) next_hit = 1'b1;
        end
    end

    assign elig = ((state_q == ST_IDLE) ? req_instr : cur_instr_q) ? alloc_instr_en
                                                                   : alloc_data_en;

    lrb_victim_sel #(.NBUF(NBUF)) u_victim (
        .rank     (rank),
        .elig     (elig),
        .victim   (victim),
        .any_elig (any_elig)
    );

    lrb_lru_rank #(.NBUF(NBUF)) u_rank (
        .clk         (clk),
        .rst_n       (rst_n),
        .promote     (promote),
        .promote_idx (promote_idx),
        .rank        (rank)
    );

    assign take_hit  = (state_q == ST_IDLE) && req_valid && hit;
    assign take_miss = (state_q == ST_IDLE) && req_valid && !hit;
    assign fill_ack  = (state_q == ST_FETCH) && arr_ack;
    assign pf_ack    = (state_q == ST_PREFETCH) && arr_ack;
    assign pf_go     = pf_type_ok(pf_mode, cur_instr_q) && pf_master_en[cur_master_q]
                       && !next_hit && any_elig;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (take_miss) state_d = ST_FETCH;                        // T_MISS
            ST_FETCH:    if (arr_ack)   state_d = pf_go ? ST_PREFETCH : ST_IDLE;  // T_FILL_PF / T_FILL
            ST_PREFETCH: if (arr_ack)   state_d = ST_IDLE;                        // T_PF_DONE
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        resp_valid  = 1'b0;
        resp_data   = '0;
        arr_req     = 1'b0;
        promote     = 1'b0;
        promote_idx = victim;
        unique case (state_q)
            ST_IDLE: begin
                if (take_hit) begin
                    resp_valid  = 1'b1;
                    resp_data   = line_q[hit_idx][int'(req_word)*DATA_W +: DATA_W];
                    promote     = 1'b1;
                    promote_idx = hit_idx;
                end
            end
            ST_FETCH: begin
                arr_req = 1'b1;
                if (arr_ack) begin
                    resp_valid = 1'b1;
                    resp_data  = arr_line[int'(cur_word_q)*DATA_W +: DATA_W];
                    promote    = any_elig;
                end
            end
            ST_PREFETCH: arr_req = 1'b1;
            default: ;
        endcase
    end

    assign arr_line_addr = arr_addr_q;

    // Buffer storage and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q        <= '0;
            cur_word_q   <= '0;
            cur_instr_q  <= 1'b0;
            cur_master_q <= '0;
            arr_addr_q   <= '0;
            for (int i = 0; i < NBUF; i++) begin
                tag_q[i]  <= '0;
                line_q[i] <= '0;
            end
        end else begin
            if (take_miss) begin
                arr_addr_q   <= req_line;
                cur_word_q   <= req_word;
                cur_instr_q  <= req_instr;
                cur_master_q <= req_master;
            end
            if ((fill_ack || pf_ack) && any_elig) begin
                vld_q[victim]  <= 1'b1;
                tag_q[victim]  <= arr_addr_q;
                line_q[victim] <= arr_line;
            end
            if (fill_ack && pf_go) arr_addr_q <= next_line;
        end
    end

    a_r2_arr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !arr_ack) |=> (arr_req && $stable(arr_line_addr)));

    a_r1_hit_mru: assert property (@(posedge clk) disable iff (!rst_n)
        take_hit |=> (rank[$past(hit_idx)] == '0));

    a_r3_fill_mru: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_ack && any_elig) |=> (rank[$past(victim)] == '0));

    a_r7_prefetch_keeps_rank: assert property (@(posedge clk) disable iff (!rst_n)
        pf_ack |=> $stable(rank));

    a_r8_silent_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PREFETCH) |-> !resp_valid);

    a_r9_victim_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        any_elig |-> elig[victim]);

endmodule

// File: tb/lrb_prefetch_ctrl_tb.sv
`timescale 1ns/1ps
module lrb_prefetch_ctrl_tb;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_instr = 1'b0;
    logic [1:0]  req_master = '0;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic [1:0]  pf_mode = 2'b00;
    logic [3:0]  pf_master_en = 4'hF;
    logic [3:0]  alloc_instr_en = 4'hF;
    logic [3:0]  alloc_data_en = 4'hF;
    logic        arr_req;
    logic [13:0] arr_line_addr;
    logic        arr_ack = 1'b0;
    logic [127:0] arr_line = '0;

    int checks = 0;
    int fails = 0;
    int arr_cnt = 0;
    logic [13:0] last_arr = '0;

    always #2.5 clk = ~clk;

    lrb_prefetch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_instr(req_instr), .req_master(req_master), .resp_valid(resp_valid),
        .resp_data(resp_data), .pf_mode(pf_mode), .pf_master_en(pf_master_en),
        .alloc_instr_en(alloc_instr_en), .alloc_data_en(alloc_data_en),
        .arr_req(arr_req), .arr_line_addr(arr_line_addr), .arr_ack(arr_ack),
        .arr_line(arr_line)
    );

    function automatic logic [31:0] wdata(input logic [13:0] line, input logic [1:0] w);
        return {8'hC5, 2'b00, line, 6'b000000, w};
    endfunction

    // Array model: acks LAT cycles after a request, holding ack for one cycle
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                arr_ack = 1'b0;
                cnt = 0;
            end else if (arr_ack) begin
                arr_ack = 1'b0;
                cnt = 0;
            end else if (arr_req) begin
                cnt++;
                if (cnt == LAT) begin
                    for (int w = 0; w < 4; w++)
                        arr_line[w*32 +: 32] = wdata(arr_line_addr, 2'(w));
                    arr_ack = 1'b1;
                    arr_cnt++;
                    last_arr = arr_line_addr;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, input logic ins, input logic [1:0] m,
                      output logic [31:0] d, output logic h, output int waited);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_instr = ins; req_master = m;
        waited = 0;
        #1;
        while (!resp_valid && waited < 60) begin
            @(negedge clk);
            #1;
            waited++;
        end
        h = (waited == 0);
        d = resp_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Read and check hit/miss and data
    task automatic rdc(input string req, input logic [15:0] a, input logic ins,
                       input logic [1:0] m, input logic exp_hit);
        logic [31:0] d;
        logic h;
        int wt;
        rd(a, ins, m, d, h, wt);
        check({req, " hit"}, 32'(h), 32'(exp_hit));
        check({req, " data"}, d, wdata(a[15:2], a[1:0]));
    endtask

    // {exp_hit, instr, addr}, prefetch off, all buffers enabled
    localparam logic [17:0] VEC [12] = '{
        {1'b0, 1'b1, 16'h0010}, {1'b1, 1'b0, 16'h0011}, {1'b0, 1'b1, 16'h0020},
        {1'b0, 1'b0, 16'h0030}, {1'b0, 1'b1, 16'h0040}, {1'b1, 1'b1, 16'h0013},
        {1'b0, 1'b0, 16'h0050}, {1'b1, 1'b0, 16'h0012}, {1'b0, 1'b1, 16'h0022},
        {1'b0, 1'b1, 16'h0033}, {1'b0, 1'b0, 16'h0041}, {1'b1, 1'b1, 16'h0021}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int c0;
        logic [31:0] d;
        logic h;
        int wt;

        // R10: reset state
        do_reset();
        #1;
        check("R10 resp_valid", 32'(resp_valid), 0);
        check("R10 arr_req", 32'(arr_req), 0);
        rdc("R10 first read misses", 16'h0010, 1'b0, 2'd0, 1'b0);

        // R1 R2 R3: table walk, LRU eviction order
        do_reset();
        for (int i = 0; i < 12; i++)
            rdc("R1/R2/R3 table", VEC[i][15:0], VEC[i][16], 2'd0, VEC[i][17]);

        // R2: array address presented on a miss
        c0 = arr_cnt;
        rdc("R2 miss", 16'h0ABC, 1'b0, 2'd0, 1'b0);
        check("R2 arr addr", 32'(last_arr), 32'(14'h02AF));
        check("R2 one access", 32'(arr_cnt - c0), 1);

        // R4 R6: instruction-only mode
        do_reset();
        pf_mode = 2'b01;
        c0 = arr_cnt;
        rdc("R4 instr miss", 16'h0100, 1'b1, 2'd0, 1'b0);
        idle(8);
        check("R4 instr prefetch count", 32'(arr_cnt - c0), 2);
        check("R6 prefetch addr", 32'(last_arr), 32'(14'h0041));
        rdc("R6 prefetched hit", 16'h0105, 1'b1, 2'd0, 1'b1);
        c0 = arr_cnt;
        rdc("R4 data miss", 16'h0200, 1'b0, 2'd0, 1'b0);
        idle(8);
        check("R4 data no prefetch", 32'(arr_cnt - c0), 1);
        pf_mode = 2'b10;
        c0 = arr_cnt;
        rdc("R4 data-mode miss", 16'h0300, 1'b0, 2'd0, 1'b0);
        idle(8);
        check("R4 data-mode prefetch", 32'(arr_cnt - c0), 2);

        // R5: per-master enable
        do_reset();
        pf_mode = 2'b11;
        pf_master_en = 4'b1101;
        c0 = arr_cnt;
        rdc("R5 master1", 16'h0400, 1'b1, 2'd1, 1'b0);
        idle(8);
        check("R5 master1 no prefetch", 32'(arr_cnt - c0), 1);
        c0 = arr_cnt;
        rdc("R5 master2", 16'h0500, 1'b0, 2'd2, 1'b0);
        idle(8);
        check("R5 master2 prefetch", 32'(arr_cnt - c0), 2);
        pf_master_en = 4'hF;

        // R6: next line already buffered suppresses prefetch
        do_reset();
        pf_mode = 2'b00;
        rdc("R6 seed", 16'h0044, 1'b0, 2'd0, 1'b0);
        pf_mode = 2'b11;
        c0 = arr_cnt;
        rdc("R6 miss", 16'h0040, 1'b0, 2'd0, 1'b0);
        idle(8);
        check("R6 no duplicate prefetch", 32'(arr_cnt - c0), 1);

        // R8: request during prefetch waits, then hits
        do_reset();
        pf_mode = 2'b11;
        c0 = arr_cnt;
        rdc("R8 miss", 16'h0600, 1'b1, 2'd0, 1'b0);
        rd(16'h0606, 1'b1, 2'd0, d, h, wt);
        check("R8 waited", 32'(wt > 0), 1);
        check("R8 data", d, wdata(14'h0181, 2'd2));
        check("R8 no extra access", 32'(arr_cnt - c0), 2);

        // R7: prefetched line stays LRU and is evicted first
        do_reset();
        pf_mode = 2'b11;
        rdc("R7 seed", 16'h0004, 1'b0, 2'd0, 1'b0);
        idle(8);
        pf_mode = 2'b00;
        rdc("R7 fill a", 16'h0028, 1'b0, 2'd0, 1'b0);
        rdc("R7 fill b", 16'h002C, 1'b0, 2'd0, 1'b0);
        rdc("R7 prefetched evicted", 16'h0008, 1'b0, 2'd0, 1'b0);

        // R7: a hit promotes the prefetched line
        do_reset();
        pf_mode = 2'b11;
        rdc("R7 seed2", 16'h0004, 1'b0, 2'd0, 1'b0);
        idle(8);
        pf_mode = 2'b00;
        rdc("R7 promote hit", 16'h0008, 1'b0, 2'd0, 1'b1);
        rdc("R7 fill c", 16'h0028, 1'b0, 2'd0, 1'b0);
        rdc("R7 fill d", 16'h002C, 1'b0, 2'd0, 1'b0);
        rdc("R7 promoted kept", 16'h0009, 1'b0, 2'd0, 1'b1);
        rdc("R7 demand kept", 16'h0005, 1'b0, 2'd0, 1'b1);

        // R9: allocation masks
        do_reset();
        alloc_data_en = 4'b0000;
        rdc("R9 data no alloc", 16'h0700, 1'b0, 2'd0, 1'b0);
        rdc("R9 data again miss", 16'h0701, 1'b0, 2'd0, 1'b0);
        rdc("R9 instr alloc", 16'h0702, 1'b1, 2'd0, 1'b0);
        rdc("R9 instr hit", 16'h0703, 1'b1, 2'd0, 1'b1);
        rdc("R9 data lookup hit", 16'h0700, 1'b0, 2'd0, 1'b1);
        do_reset();
        alloc_instr_en = 4'b0001;
        rdc("R9 single buf a", 16'h0800, 1'b1, 2'd0, 1'b0);
        rdc("R9 single buf b", 16'h0810, 1'b1, 2'd0, 1'b0);
        rdc("R9 single buf evicted", 16'h0800, 1'b1, 2'd0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule